// File: doc/BRIEF.md
# Multiplexed DRAM Address Controller

This block turns one memory request into a row/column strobe sequence for four DRAM banks. A request is a 10-bit address, a read flag, a write flag and a latch-enable pulse. The controller captures the request, places the row nibble on a shared 4-bit address bus and then lowers the row strobe of the addressed bank. It then places the column nibble on the same bus, drives the write-enable output, lowers the shared column strobe, and finally releases everything and returns to idle.

Each strobe follows its address by exactly one clock, so the bank always sees a settled address when a strobe edge arrives. The two top address bits pick which of the four per-bank row strobes is used. The column strobe and the write-enable output are shared by all banks. The memory arrays and any data path sit outside this block.

Top module: `muxAddrStrobeCtrl`

## Requirements
- R1: While `rst` is 1, and on the first clock edge after it, all four row strobes and the column strobe are 1 (inactive), `writeEn` is 0 and `addrOut` is 0.
- R2: In idle, when `latchEn` is 0, the block starts no sequence: strobes stay high, `writeEn` stays 0 and `addrOut` keeps its value, whatever `addrIn`, `rdIn` and `wrIn` do.
- R3: On an edge where `latchEn` is 1 in idle with a valid operation, the request is captured and `addrOut` shows `addrIn[7:4]` (the row nibble) after that same edge.
- R4: One edge after the row nibble appears, `rowStrobeN[b]` goes to 0 for b = {`addrIn[9]`,`addrIn[8]`} and the other three row strobes stay 1.
- R5: One edge after the row strobe falls, `addrOut` shows `addrIn[3:0]` (the column nibble); one edge later `colStrobeN` goes to 0, with `addrOut` unchanged.
- R6: `writeEn` becomes 1 together with the column nibble when the request was a write (`rdIn`=0, `wrIn`=1), and stays 0 for a read (`rdIn`=1, `wrIn`=0); it returns to 0 at release.
- R7: A request with `rdIn` equal to `wrIn` (both 0 or both 1) is ignored: no strobe falls and the block stays idle.
- R8: The column strobe is low for exactly one cycle; on the next edge all strobes rise together and `writeEn` clears; on that same cycle the block is idle and accepts a new request on the following edge.
- R9: `latchEn` and the request inputs are ignored while a sequence is in progress; the captured nibbles and bank are the ones used to the end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addrIn | input | 10 | Request address: bank in [9:8], row in [7:4], column in [3:0] |
| rdIn | input | 1 | Read request flag |
| wrIn | input | 1 | Write request flag |
| latchEn | input | 1 | Capture the request when 1 in idle |
| addrOut | output | 4 | Shared multiplexed row/column address |
| rowStrobeN | output | 4 | Per-bank row strobes, active low, bit b for bank b |
| colStrobeN | output | 1 | Shared column strobe, active low |
| writeEn | output | 1 | 1 during a write sequence's column phase |

## Verification
The embedded assertions watch, on every cycle, that at most one row strobe is low, that the address bus is still when either strobe falls, that the column strobe never stays low two cycles and only falls under an open row, that write-enable is only high under an open row, and that the controller stays idle on an absent or invalid request. Which bank is chosen, which nibble goes on the bus, the exact cycle each strobe falls and the read/write polarity of write-enable can only be shown by the bench, which sweeps every address with both operations, back to back, plus invalid flags and enables issued mid-sequence.

// File: rtl/muxAddrPkg.sv
package muxAddrPkg;

  // Per-cycle commands from the sequencer to the datapath
  typedef struct packed {
    logic load;      // capture request, show row nibble
    logic rowOn;     // drop selected row strobe
    logic driveCol;  // show column nibble, set write enable
    logic colOn;     // drop column strobe
    logic drop;      // release strobes, clear write enable
  } seqStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW_ADDR,
    ST_ROW_STB,
    ST_COL_ADDR,
    ST_COL_STB
  } seqState_t;

endpackage

// File: rtl/muxAddrSeq.sv
module muxAddrSeq
  import muxAddrPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       latchEn,
  input  logic       rdIn,
  input  logic       wrIn,
  output seqStrobe_t ctl
);

  seqState_t state, nextState;
  logic      reqValid;

  assign reqValid = latchEn && (rdIn ^ wrIn);

  always_comb begin
    nextState = state;
    ctl       = '0;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        ctl.load  = 1'b1;
        nextState = ST_ROW_ADDR;
      end
      ST_ROW_ADDR: begin
        ctl.rowOn = 1'b1;
        nextState = ST_ROW_STB;
      end
      ST_ROW_STB: begin
        ctl.driveCol = 1'b1;
        nextState    = ST_COL_ADDR;
      end
      ST_COL_ADDR: begin
        ctl.colOn = 1'b1;
        nextState = ST_COL_STB;
      end
      ST_COL_STB: begin
        ctl.drop  = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  // R2 R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !reqValid) |=> (state == ST_IDLE));

  // R8
  return_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_COL_STB) |=> (state == ST_IDLE));

  // R9
  busy_no_load_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> !ctl.load);

endmodule

// File: rtl/muxAddrPath.sv
module muxAddrPath
  import muxAddrPkg::*;
#(
  parameter int NIB_W  = 4,
  parameter int BANK_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  seqStrobe_t              ctl,
  input  logic [BANK_W+2*NIB_W-1:0] addrIn,
  input  logic                    wrIn,
  output logic [NIB_W-1:0]        addrOut,
  output logic [(1<<BANK_W)-1:0]  rowStrobeN,
  output logic                    colStrobeN,
  output logic                    writeEn
);

  localparam int NUM_BANKS = 1 << BANK_W;

  logic [NIB_W-1:0]  colReg;
  logic [BANK_W-1:0] bankReg;
  logic              wrReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      colReg     <= '0;
      bankReg    <= '0;
      wrReg      <= 1'b0;
      addrOut    <= '0;
      colStrobeN <= 1'b1;
      writeEn    <= 1'b0;
    end else begin
      if (ctl.load) begin
        colReg  <= addrIn[NIB_W-1:0];
        bankReg <= addrIn[BANK_W+2*NIB_W-1:2*NIB_W];
        wrReg   <= wrIn;
        addrOut <= addrIn[2*NIB_W-1:NIB_W];
      end
      if (ctl.driveCol) begin
        addrOut <= colReg;
        writeEn <= wrReg;
      end
      if (ctl.colOn) colStrobeN <= 1'b0;
      if (ctl.drop) begin
        colStrobeN <= 1'b1;
        writeEn    <= 1'b0;
      end
    end
  end

  // One row strobe flop per bank
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_rowStb
    always_ff @(posedge clk) begin
      if (rst)                                         rowStrobeN[b] <= 1'b1;
      else if (ctl.rowOn && bankReg == BANK_W'(b))     rowStrobeN[b] <= 1'b0;
      else if (ctl.drop)                               rowStrobeN[b] <= 1'b1;
    end
  end

  // R4
  one_row_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~rowStrobeN));

  // R4
  row_addr_settled_chk: assert property (@(posedge clk) disable iff (rst)
    ((&$past(rowStrobeN)) && !(&rowStrobeN)) |-> $stable(addrOut));

  // R5
  col_addr_settled_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(colStrobeN) |-> $stable(addrOut));

  // R5
  col_under_row_chk: assert property (@(posedge clk) disable iff (rst)
    !colStrobeN |-> ($countones(~rowStrobeN) == 1));

  // R8
  col_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    !colStrobeN |=> (colStrobeN && (&rowStrobeN)));

  // R6
  we_under_row_chk: assert property (@(posedge clk) disable iff (rst)
    writeEn |-> !(&rowStrobeN));

endmodule

// File: rtl/muxAddrStrobeCtrl.sv
module muxAddrStrobeCtrl
  import muxAddrPkg::*;
#(
  parameter int NIB_W  = 4,
  parameter int BANK_W = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [BANK_W+2*NIB_W-1:0] addrIn,
  input  logic                      rdIn,
  input  logic                      wrIn,
  input  logic                      latchEn,
  output logic [NIB_W-1:0]          addrOut,
  output logic [(1<<BANK_W)-1:0]    rowStrobeN,
  output logic                      colStrobeN,
  output logic                      writeEn
);

  seqStrobe_t ctl;

  muxAddrSeq u_seq (
    .clk    (clk),
    .rst    (rst),
    .latchEn(latchEn),
    .rdIn   (rdIn),
    .wrIn   (wrIn),
    .ctl    (ctl)
  );

  muxAddrPath #(.NIB_W(NIB_W), .BANK_W(BANK_W)) u_path (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .addrIn    (addrIn),
    .wrIn      (wrIn),
    .addrOut   (addrOut),
    .rowStrobeN(rowStrobeN),
    .colStrobeN(colStrobeN),
    .writeEn   (writeEn)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> ((&rowStrobeN) && colStrobeN && !writeEn));

endmodule

// File: tb/tb_muxAddrStrobeCtrl.sv
module tb_muxAddrStrobeCtrl;

  logic       clk = 1'b0;
  logic       rst;
  logic [9:0] addrIn;
  logic       rdIn, wrIn, latchEn;
  logic [3:0] addrOut;
  logic [3:0] rowStrobeN;
  logic       colStrobeN, writeEn;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  muxAddrStrobeCtrl dut (
    .clk(clk), .rst(rst), .addrIn(addrIn), .rdIn(rdIn), .wrIn(wrIn),
    .latchEn(latchEn), .addrOut(addrOut), .rowStrobeN(rowStrobeN),
    .colStrobeN(colStrobeN), .writeEn(writeEn)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chkIdle(input string req, input logic [3:0] expAddr);
    chk(req, "rowStrobeN", 32'(rowStrobeN), 32'hF);
    chk(req, "colStrobeN", 32'(colStrobeN), 32'h1);
    chk(req, "writeEn",    32'(writeEn),    32'h0);
    chk(req, "addrOut",    32'(addrOut),    32'(expAddr));
  endtask

  // Starts at a negedge; issues one valid request and checks every phase.
  // busyNoise drives a different request during the sequence (R9).
  task automatic runReq(input logic [9:0] a, input logic isWr, input bit busyNoise);
    logic [3:0] rowMask;
    rowMask = ~(4'b0001 << a[9:8]);
    addrIn = a; rdIn = ~isWr; wrIn = isWr; latchEn = 1'b1;
    @(negedge clk);  // after capture edge
    // R3
    chk("R3", "row nibble", 32'(addrOut), 32'(a[7:4]));
    chk("R3", "strobes high", 32'({rowStrobeN, colStrobeN}), 32'h1F);
    if (busyNoise) begin
      addrIn = ~a; rdIn = isWr; wrIn = ~isWr; latchEn = 1'b1;
    end else latchEn = 1'b0;
    @(negedge clk);
    // R4
    chk("R4", "bank row strobe", 32'(rowStrobeN), 32'(rowMask));
    chk("R4", "row nibble held", 32'(addrOut), 32'(a[7:4]));
    chk("R4", "col strobe high", 32'(colStrobeN), 32'h1);
    @(negedge clk);
    // R5 R6
    chk("R5", "col nibble", 32'(addrOut), 32'(a[3:0]));
    chk("R5", "col strobe not yet", 32'(colStrobeN), 32'h1);
    chk("R6", "writeEn", 32'(writeEn), 32'(isWr));
    chk("R9", "row strobe kept", 32'(rowStrobeN), 32'(rowMask));
    @(negedge clk);
    latchEn = 1'b0;
    chk("R5", "col strobe low", 32'(colStrobeN), 32'h0);
    chk("R5", "col nibble held", 32'(addrOut), 32'(a[3:0]));
    chk("R6", "writeEn held", 32'(writeEn), 32'(isWr));
    chk("R8", "row strobe with col", 32'(rowStrobeN), 32'(rowMask));
    @(negedge clk);
    // R8
    chkIdle("R8", a[3:0]);
  endtask

  initial begin
    rst = 1'b1; addrIn = 10'h3FF; rdIn = 1'b1; wrIn = 1'b0; latchEn = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    chkIdle("R1", 4'h0);
    rst = 1'b0; latchEn = 1'b0;

    // R2: inputs wiggle without latchEn
    for (int i = 0; i < 16; i++) begin
      addrIn = 10'(i * 67); rdIn = i[0]; wrIn = ~i[0];
      @(negedge clk);
      chkIdle("R2", 4'h0);
    end

    // R7: invalid flag pairs with latchEn
    for (int i = 0; i < 32; i++) begin
      addrIn = 10'(i * 37); rdIn = i[0]; wrIn = i[0]; latchEn = 1'b1;
      @(negedge clk);
      chkIdle("R7", 4'h0);
    end
    latchEn = 1'b0;
    @(negedge clk);
    chkIdle("R7", 4'h0);

    // Full sweep, both operations, back to back (R3..R6, R8)
    for (int a = 0; a < 1024; a++) begin
      runReq(10'(a), 1'b0, 1'b0);
      runReq(10'(a), 1'b1, 1'b0);
    end

    // R9: enable and new request held during a busy sequence
    runReq(10'h2A5, 1'b1, 1'b1);
    runReq(10'h15A, 1'b0, 1'b1);
    @(negedge clk);
    chkIdle("R9", 4'hA);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule